// File: doc/BRIEF.md
# Multi-Mode Logarithmic Word Shifter

A purely combinational shifter for a WIDTH-bit word (8 bits by default, any power of two of at least 2). The shift amount is taken as an unsigned value of log2(WIDTH) bits. The block resolves the amount as a sum of powers of two, with one mux stage for each bit of the amount. Stage s moves the word by 2^s places when amount bit s is set and passes it on unchanged when the bit is clear. A shift by k places therefore yields the same word as k shifts of one place each.

A three-bit opcode selects one of five shift kinds, and each kind has its own fill rule. The logical kinds fill vacated positions with zeros. The arithmetic right shift fills with the sign bit. The rotations feed the bits that leave one end back in at the other end.

The output follows the inputs within the same cycle, so the shifter sits directly in an execute path. No register or flag is added.

Top module: `log_shifter`

## Requirements
- R1: With op = 3'b000 (logical left), dout equals din moved toward the MSB by amount places; the low amount bits of dout are 0 and the bits that leave the top are dropped.
- R2: With op = 3'b001 (logical right), dout equals din moved toward the LSB by amount places; the high amount bits of dout are 0.
- R3: With op = 3'b010 (arithmetic right), dout equals din moved toward the LSB by amount places; every vacated high bit takes the value of din's MSB, so dout's MSB always equals din's MSB.
- R4: With op = 3'b011 (rotate left), the bits that leave the MSB end reappear at the LSB end; no bit is lost and the number of ones is unchanged.
- R5: With op = 3'b100 (rotate right), the bits that leave the LSB end reappear at the MSB end; no bit is lost and the number of ones is unchanged.
- R6: The amount is an unsigned value from 0 to WIDTH-1; an amount of 0 returns din unchanged in every mode.
- R7: The opcodes 3'b101, 3'b110 and 3'b111 return din unchanged, whatever the amount.
- R8: For din = 8'h96 and amount = 1, the results are 8'h2C (logical left), 8'h4B (logical right), 8'hCB (arithmetic right), 8'h2D (rotate left) and 8'h4B (rotate right).
- R9: A shift by k places in any mode gives the same result as k shifts of one place each in that mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | WIDTH | Word to be shifted |
| amount | input | log2(WIDTH) | Shift distance in places |
| op | input | 3 | Shift kind: 000 logical left, 001 logical right, 010 arithmetic right, 011 rotate left, 100 rotate right; other codes pass din through |
| dout | output | WIDTH | Shifted word |

## Verification
The block holds no state, so the only internal fault it can have is a stage that moves the wrong distance or inserts the wrong fill bits. Such a fault appears at dout in the same cycle, but only for the amounts whose bit selects that stage. The bench therefore sweeps every amount under every opcode, including the three unused codes, against a reference that repeats single-place moves. An error confined to one stage shows up for exactly the amounts that use it, and it shows up at once. Fill faults show best on words with a set MSB and on words with a set LSB, so the data set contains both.

// File: rtl/log_shifter.sv
module log_shifter #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]         din,
  input  logic [$clog2(WIDTH)-1:0] amount,
  input  logic [2:0]               op,
  output logic [WIDTH-1:0]         dout
);
  localparam int STAGES = $clog2(WIDTH);

  localparam logic [2:0] OP_LSL = 3'b000;
  localparam logic [2:0] OP_LSR = 3'b001;
  localparam logic [2:0] OP_ASR = 3'b010;
  localparam logic [2:0] OP_ROL = 3'b011;
  localparam logic [2:0] OP_ROR = 3'b100;

  logic go_left, rotating, sign_fill, known_op;
  logic [WIDTH-1:0] stage [STAGES+1];

  assign go_left   = (op == OP_LSL) || (op == OP_ROL);
  assign rotating  = (op == OP_ROL) || (op == OP_ROR);
  assign sign_fill = (op == OP_ASR) && din[WIDTH-1];
  assign known_op  = (op <= OP_ROR);

  assign stage[0] = din;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int D = 1 << s;
    logic [D-1:0]     fill_lo, fill_hi;
    logic [WIDTH-1:0] moved_l, moved_r;

    assign fill_lo = rotating ? stage[s][WIDTH-1:WIDTH-D] : '0;
    assign fill_hi = rotating  ? stage[s][D-1:0] :
                     sign_fill ? {D{1'b1}} : '0;
    assign moved_l = {stage[s][WIDTH-1-D:0], fill_lo};
    assign moved_r = {fill_hi, stage[s][WIDTH-1:D]};
    assign stage[s+1] = !amount[s] ? stage[s] : (go_left ? moved_l : moved_r);
  end

  assign dout = known_op ? stage[STAGES] : din;
endmodule

// File: rtl/log_shifter_chk.sv
module log_shifter_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0]         din,
  input logic [$clog2(WIDTH)-1:0] amount,
  input logic [2:0]               op,
  input logic [WIDTH-1:0]         dout
);
  logic [WIDTH-1:0] low_mask;
  logic [WIDTH-1:0] high_mask;
  assign low_mask  = (WIDTH'(1) << amount) - WIDTH'(1);
  assign high_mask = ~({WIDTH{1'b1}} >> amount);

  always_comb begin
    if (op == 3'b000)
      AST_LSL_LOW_ZERO: assert ((dout & low_mask) == '0); // R1
    if (op == 3'b001)
      AST_LSR_HIGH_ZERO: assert ((dout & high_mask) == '0); // R2
    if (op == 3'b010)
      AST_ASR_SIGN_KEPT: assert (dout[WIDTH-1] == din[WIDTH-1]); // R3
    if (op == 3'b011)
      AST_ROL_ONES_KEPT: assert ($countones(dout) == $countones(din)); // R4
    if (op == 3'b100)
      AST_ROR_ONES_KEPT: assert ($countones(dout) == $countones(din)); // R5
    if (amount == '0)
      AST_ZERO_AMOUNT_IDENT: assert (dout == din); // R6
    if (op > 3'b100)
      AST_SPARE_OP_PASS: assert (dout == din); // R7
  end
endmodule

bind log_shifter log_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .din(din), .amount(amount), .op(op), .dout(dout)
);

// File: tb/log_shifter_tb.sv
module log_shifter_tb;
  localparam int W = 8;
  localparam int CW = $clog2(W);
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0]  din = '0;
  logic [CW-1:0] amount = '0;
  logic [2:0]    op = 3'b111;
  logic [W-1:0]  dout;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  log_shifter #(.WIDTH(W)) u_dut (.din(din), .amount(amount), .op(op), .dout(dout));

  function automatic logic [W-1:0] one_step(logic [W-1:0] v, logic [2:0] m);
    case (m)
      3'd0: return v << 1;
      3'd1: return v >> 1;
      3'd2: return {v[W-1], v[W-1:1]};
      3'd3: return {v[W-2:0], v[W-1]};
      3'd4: return {v[0], v[W-1:1]};
      default: return v;
    endcase
  endfunction

  function automatic logic [W-1:0] model(logic [W-1:0] v, int k, logic [2:0] m);
    logic [W-1:0] r = v;
    for (int i = 0; i < k; i++) r = one_step(r, m);
    return r;
  endfunction

  function automatic string req_of(logic [2:0] m, int k);
    if (m > 3'd4) return "R7";
    if (k == 0) return "R6";
    case (m)
      3'd0: return "R1/R9";
      3'd1: return "R2/R9";
      3'd2: return "R3/R9";
      3'd3: return "R4/R9";
      default: return "R5/R9";
    endcase
  endfunction

  task automatic apply_check(logic [W-1:0] d, int k, logic [2:0] m, logic [W-1:0] exp, string req);
    @(posedge clk);
    din = d; amount = CW'(k); op = m;
    @(negedge clk);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s: din=%h amount=%0d op=%0d got %h expected %h", req, d, k, m, dout, exp);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    checks++;
    if (dout !== din) begin
      errors++;
      $display("FAIL R7: reset-time pass-through got %h expected %h", dout, din);
    end
    // R8 worked examples
    apply_check(8'h96, 1, 3'd0, 8'h2C, "R8");
    apply_check(8'h96, 1, 3'd1, 8'h4B, "R8");
    apply_check(8'h96, 1, 3'd2, 8'hCB, "R8");
    apply_check(8'h96, 1, 3'd3, 8'h2D, "R8");
    apply_check(8'h96, 1, 3'd4, 8'h4B, "R8");
    // full sweep: directed words plus random ones
    for (int t = 0; t < 24; t++) begin
      logic [W-1:0] d;
      case (t)
        0: d = 8'h96;
        1: d = 8'h80;
        2: d = 8'h01;
        3: d = 8'hFF;
        4: d = 8'h00;
        5: d = 8'hA5;
        default: d = W'($urandom);
      endcase
      for (int m = 0; m < 8; m++)
        for (int k = 0; k < W; k++)
          apply_check(d, k, 3'(m), model(d, k, 3'(m)), req_of(3'(m), k));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule